// File: doc/BRIEF.md
# Dual-Half NAND Hamming ECC Engine

This block sits beside the byte-wide data path of a NAND flash controller and computes a single-error-correcting Hamming code while calculation mode is active. A 512-byte sector is treated as two independent 256-byte halves. Each half gets 16 line-parity bits, built from the byte index, and 6 column-parity bits, built from the bit position inside each byte. Software then uses these codes to locate and repair a single flipped bit per half.

The engine is driven by writes to an 8-bit mode value and by 16-bit reads of the data register. A reset mode value clears both accumulators. One dummy read of the data register must follow before bytes are counted. A calculation mode folds each passing byte into the half selected by an internal byte counter. A result mode turns the data register into a three-word readout of the six code bytes in a fixed interleaved order. Any other mode value parks the engine and keeps its results until the next reset mode.

Top module: `nandEccEngine`

## Requirements
- R1: After rstN is released, rdData is 0x0000, the engine is not in result mode, and the six stored code bytes all read as 0xFF (no dummy read is needed before the first readout after rstN).
- R2: Writing mode value 0xF4 returns all code bytes to 0xFF and the byte counter to zero, even after data has been accumulated.
- R3: After mode 0xF4, data bytes are ignored until one data-register read (rdStrobe) has occurred. That dummy read does not advance the result word index.
- R4: Bytes are folded into the code only while mode 0xB4 is active. Bytes strobed in any other mode leave the results unchanged.
- R5: Line parity: with p the XOR of the 8 data bits and i the byte's 8-bit index in its half, line bit 2k is flipped by p when i[k]=0 and line bit 2k+1 is flipped by p when i[k]=1 (k=0..7). Line byte low = bits 7:0, line byte high = bits 15:8.
- R6: Column parity: CP(2b) is flipped by the XOR of the data bits whose position has bit b equal to 0, and CP(2b+1) by those whose position has bit b equal to 1 (b=0..2). The column byte is {CP5..CP0, 2'b11}.
- R7: Sector bytes 0..255 go to half A and bytes 256..511 go to half B. Bytes after the 512th are ignored.
- R8: Parity is stored inverted (every register starts at 1), so a sector of all 0xFF bytes reads back as all-ones code bytes.
- R9: Writing mode 0xD4 selects readout. Word 0 = {A line high, A line low}, word 1 = {B line low, A column}, word 2 = {B column, B line high} (high byte listed first).
- R10: In result mode each rdStrobe advances to the next word, and after word 2 it returns to word 0. Outside result mode rdData is 0x0000.
- R11: Writing mode 0x94 (or any value other than 0xF4, 0xB4, 0xD4) parks the engine. rdData reads 0, and re-entering 0xD4 returns the same three words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeWrEn | input | 1 | Mode value write strobe |
| modeVal | input | 8 | Mode value |
| dataStrobe | input | 1 | A byte passes on the NAND data path |
| dataByte | input | 8 | Byte on the data path |
| rdStrobe | input | 1 | 16-bit data-register read (dummy or result) |
| rdData | output | 16 | Result word for the current read |

## Verification
The assertions watch, on every cycle, the properties that can be stated cycle by cycle. The byte counter must stay still once the sector is full or while the dummy read is outstanding. Accumulators must hold whenever no byte is folded in. Column bytes must carry their fixed low bits. The read index must wrap from word 2 to word 0. A park command must blank the data register. The parity values themselves, the split between the halves, the interleaved byte order, and the way a reset combines with its dummy read show up only in the bench scenarios. Those scenarios compare full readouts against a model built from the line and column definitions.

// File: rtl/nandEccPkg.sv
package nandEccPkg;
  localparam int HALF_BYTES = 256;
  localparam int IDX_W      = $clog2(HALF_BYTES);
  localparam int LINE_W     = 2 * IDX_W;
  localparam int COL_W      = 6;
  localparam int CNT_W      = IDX_W + 2;
  localparam int SECTOR     = 2 * HALF_BYTES;
  localparam int WORDS      = 3;

  localparam logic [7:0] MODE_CLEAR  = 8'hF4;
  localparam logic [7:0] MODE_CALC   = 8'hB4;
  localparam logic [7:0] MODE_RESULT = 8'hD4;
  localparam logic [7:0] MODE_PARK   = 8'h94;

  typedef enum logic [1:0] {ST_PARK, ST_CALC, ST_RESULT} eccState_e;

  typedef struct packed {
    logic             clearAll;
    logic             accumEn;
    logic             halfSel;
    logic [IDX_W-1:0] byteIdx;
    logic             resultOn;
    logic [1:0]       rdSel;
  } eccStrobes_t;
endpackage

// File: rtl/nandEccCtrl.sv
module nandEccCtrl
  import nandEccPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        modeWrEn,
  input  logic [7:0]  modeVal,
  input  logic        dataStrobe,
  input  logic        rdStrobe,
  output eccStrobes_t strobes
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SECTOR);

  eccState_e        state;
  logic [CNT_W-1:0] byteCnt;
  logic             needDummy;
  logic [1:0]       rdIdx;
  logic             accumNow;
  logic             advRead;

  assign accumNow = (state == ST_CALC) && dataStrobe && !needDummy && (byteCnt != CNT_FULL);
  assign advRead  = rdStrobe && !modeWrEn && (state == ST_RESULT) && !needDummy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_PARK;
      byteCnt   <= '0;
      needDummy <= 1'b0;
      rdIdx     <= '0;
    end else begin
      if (accumNow) byteCnt <= byteCnt + 1'b1;
      if (rdStrobe) needDummy <= 1'b0;
      if (advRead) rdIdx <= (rdIdx == 2'(WORDS - 1)) ? 2'd0 : rdIdx + 2'd1;
      if (modeWrEn) begin
        unique case (modeVal)
          MODE_CLEAR: begin
            state     <= ST_PARK;
            byteCnt   <= '0;
            needDummy <= 1'b1;
          end
          MODE_CALC:   state <= ST_CALC;
          MODE_RESULT: begin
            state <= ST_RESULT;
            rdIdx <= '0;
          end
          default:     state <= ST_PARK;
        endcase
      end
    end
  end

  always_comb begin
    strobes.clearAll = modeWrEn && (modeVal == MODE_CLEAR);
    strobes.accumEn  = accumNow;
    strobes.halfSel  = byteCnt[IDX_W];
    strobes.byteIdx  = byteCnt[IDX_W-1:0];
    strobes.resultOn = (state == ST_RESULT);
    strobes.rdSel    = rdIdx;
  end

  p_cnt_full_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (byteCnt == CNT_FULL && !modeWrEn) |=> $stable(byteCnt));

  p_dummy_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    (needDummy && !modeWrEn) |=> $stable(byteCnt));

  p_read_wrap_r10: assert property (@(posedge clk) disable iff (!rstN)
    (advRead && rdIdx == 2'd2) |=> (rdIdx == 2'd0));
endmodule

// File: rtl/nandEccDatapath.sv
module nandEccDatapath
  import nandEccPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  eccStrobes_t strobes,
  input  logic [7:0]  dataByte,
  output logic [15:0] rdData
);
  logic [1:0][LINE_W-1:0] lineReg;
  logic [1:0][COL_W-1:0]  colReg;
  logic [LINE_W-1:0]      lineFlip;
  logic [COL_W-1:0]       colFlip;
  logic                   bytePar;

  function automatic logic [7:0] colMask(input int b, input logic odd);
    logic [7:0] m;
    for (int j = 0; j < 8; j++) m[j] = (((j >> b) & 1) == int'(odd));
    return m;
  endfunction

  assign bytePar = ^dataByte;

  for (genvar k = 0; k < IDX_W; k++) begin : g_line
    assign lineFlip[2*k]   = bytePar & ~strobes.byteIdx[k];
    assign lineFlip[2*k+1] = bytePar &  strobes.byteIdx[k];
  end

  for (genvar b = 0; b < 3; b++) begin : g_col
    assign colFlip[2*b]   = ^(dataByte & colMask(b, 1'b0));
    assign colFlip[2*b+1] = ^(dataByte & colMask(b, 1'b1));
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk) begin
      if (!rstN || strobes.clearAll) begin
        lineReg[h] <= '1;
        colReg[h]  <= '1;
      end else if (strobes.accumEn && (strobes.halfSel == 1'(h))) begin
        lineReg[h] <= lineReg[h] ^ lineFlip;
        colReg[h]  <= colReg[h] ^ colFlip;
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (strobes.resultOn) begin
      unique case (strobes.rdSel)
        2'd0:    rdData = {lineReg[0][15:8], lineReg[0][7:0]};
        2'd1:    rdData = {lineReg[1][7:0], colReg[0], 2'b11};
        2'd2:    rdData = {colReg[1], 2'b11, lineReg[1][15:8]};
        default: rdData = '0;
      endcase
    end
  end

  p_hold_no_accum_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.accumEn && !strobes.clearAll) |=> ($stable(lineReg) && $stable(colReg)));

  p_col_fixed_bits_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.resultOn && strobes.rdSel == 2'd1) |-> (rdData[1:0] == 2'b11));
endmodule

// File: rtl/nandEccEngine.sv
module nandEccEngine
  import nandEccPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        modeWrEn,
  input  logic [7:0]  modeVal,
  input  logic        dataStrobe,
  input  logic [7:0]  dataByte,
  input  logic        rdStrobe,
  output logic [15:0] rdData
);
  eccStrobes_t strobes;

  nandEccCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .modeWrEn(modeWrEn), .modeVal(modeVal),
    .dataStrobe(dataStrobe), .rdStrobe(rdStrobe), .strobes(strobes)
  );

  nandEccDatapath dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dataByte(dataByte), .rdData(rdData)
  );

  p_park_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    (modeWrEn && modeVal == MODE_PARK) |=> (rdData == 16'h0000));
endmodule

// File: tb/nandEccEngine_tb_top.sv
module nandEccEngine_tb_top;
  localparam realtime HALF_PERIOD = 2.5ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeWrEn = 1'b0;
  logic [7:0]  modeVal = 8'h00;
  logic        dataStrobe = 1'b0;
  logic [7:0]  dataByte = 8'h00;
  logic        rdStrobe = 1'b0;
  logic [15:0] rdData;

  int nCompared = 0;
  int nMismatch = 0;
  logic [7:0] sec [0:511];

  always #(HALF_PERIOD) clk = ~clk;

  nandEccEngine dut_i (
    .clk(clk), .rstN(rstN), .modeWrEn(modeWrEn), .modeVal(modeVal),
    .dataStrobe(dataStrobe), .dataByte(dataByte), .rdStrobe(rdStrobe), .rdData(rdData)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nCompared++;
    if (act !== exp) begin
      nMismatch++;
      $display("FAIL %s: actual %04h expected %04h", req, act, exp);
    end
  endtask

  task automatic pulseMode(input logic [7:0] v);
    modeWrEn = 1'b1; modeVal = v;
    @(negedge clk);
    modeWrEn = 1'b0;
  endtask

  task automatic pushByte(input logic [7:0] b);
    dataStrobe = 1'b1; dataByte = b;
    @(negedge clk);
    dataStrobe = 1'b0;
  endtask

  task automatic readWord(output logic [15:0] w);
    w = rdData;
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  // Model of one half from the line/column definitions (R5, R6, R8)
  function automatic logic [23:0] halfCode(input int base);
    logic [15:0] lp = '1;
    logic [5:0]  cp = '1;
    for (int j = 0; j < 256; j++) begin
      logic [7:0] d = sec[base + j];
      logic p = ^d;
      for (int k = 0; k < 8; k++) begin
        if (((j >> k) & 1) == 1) lp[2*k+1] ^= p; else lp[2*k] ^= p;
      end
      cp[0] ^= d[0] ^ d[2] ^ d[4] ^ d[6];
      cp[1] ^= d[1] ^ d[3] ^ d[5] ^ d[7];
      cp[2] ^= d[0] ^ d[1] ^ d[4] ^ d[5];
      cp[3] ^= d[2] ^ d[3] ^ d[6] ^ d[7];
      cp[4] ^= ^d[3:0];
      cp[5] ^= ^d[7:4];
    end
    return {cp, 2'b11, lp};
  endfunction

  task automatic expWords(output logic [15:0] w0, output logic [15:0] w1, output logic [15:0] w2);
    logic [23:0] a = halfCode(0);
    logic [23:0] b = halfCode(256);
    w0 = a[15:0];
    w1 = {b[7:0], a[23:16]};
    w2 = {b[23:16], b[15:8]};
  endtask

  task automatic sendSector(input int extra);
    for (int i = 0; i < 512; i++) pushByte(sec[i]);
    for (int i = 0; i < extra; i++) pushByte(8'h77);
  endtask

  task automatic readAndCompare(input string req);
    logic [15:0] e0, e1, e2, w;
    expWords(e0, e1, e2);
    pulseMode(8'hD4);
    readWord(w); check({req, " word0"}, w, e0);
    readWord(w); check({req, " word1"}, w, e1);
    readWord(w); check({req, " word2"}, w, e2);
  endtask

  task automatic freshStart();
    logic [15:0] w;
    pulseMode(8'hF4);
    readWord(w);  // dummy read
    pulseMode(8'hB4);
  endtask

  task automatic testReset();
    logic [15:0] w;
    check("R1 idle rdData", rdData, 16'h0000);
    pulseMode(8'hD4);
    for (int i = 0; i < 3; i++) begin
      readWord(w); check("R1 reset code", w, 16'hFFFF);
    end
  endtask

  task automatic testErased();
    for (int i = 0; i < 512; i++) sec[i] = 8'hFF;
    freshStart();
    sendSector(0);
    readAndCompare("R8 erased");
  endtask

  task automatic testPattern();
    logic [15:0] w, e0, e1, e2;
    for (int i = 0; i < 512; i++) sec[i] = 8'((i * 73 + 29) ^ (i >> 3));
    freshStart();
    sendSector(8);  // R7: bytes after 512 ignored
    readAndCompare("R5 R6 R9 pattern");
    expWords(e0, e1, e2);
    readWord(w); check("R10 wrap to word0", w, e0);
    readWord(w); check("R10 wrap word1", w, e1);
    pulseMode(8'h94);
    check("R11 park rdData", rdData, 16'h0000);
    pulseMode(8'h13);
    pushByte(8'h01);  // R4: ignored while parked
    pushByte(8'h80);
    check("R10 rdData outside result", rdData, 16'h0000);
    readAndCompare("R11 R4 kept after park");
  endtask

  task automatic testSplit();
    for (int i = 0; i < 512; i++) sec[i] = 8'h00;
    sec[300] = 8'h01;
    freshStart();
    sendSector(0);
    readAndCompare("R7 half split");
    for (int i = 0; i < 512; i++) sec[i] = 8'h00;
    sec[37] = 8'hA4;
    sec[200] = 8'h10;
    freshStart();
    sendSector(0);
    readAndCompare("R5 R6 half A only");
  endtask

  task automatic testDummy();
    logic [15:0] w;
    for (int i = 0; i < 512; i++) sec[i] = 8'(i * 5 + 1);
    pulseMode(8'hF4);
    pulseMode(8'hB4);
    pushByte(8'h5A);  // before dummy read: ignored
    pushByte(8'h01);
    pushByte(8'h3C);
    readWord(w);      // dummy read
    sendSector(0);
    readAndCompare("R3 dummy gate");
    // dummy read while in result mode must not advance the index
    for (int i = 0; i < 512; i++) sec[i] = 8'hFF;
    pulseMode(8'hF4);
    pulseMode(8'hD4);
    readWord(w);      // dummy
    readWord(w); check("R3 dummy no advance", w, 16'hFFFF);
  endtask

  task automatic testClear();
    logic [15:0] w;
    for (int i = 0; i < 512; i++) sec[i] = 8'(i + 3);
    freshStart();
    for (int i = 0; i < 100; i++) pushByte(sec[i]);
    pulseMode(8'hF4);
    readWord(w);
    pulseMode(8'hD4);
    for (int i = 0; i < 3; i++) begin
      readWord(w); check("R2 clear mid-sector", w, 16'hFFFF);
    end
    pulseMode(8'hB4);
    sendSector(0);  // counter restarted at zero
    readAndCompare("R2 R7 count restart");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testErased();
    testPattern();
    testSplit();
    testDummy();
    testClear();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  end

  initial begin
    #(HALF_PERIOD * 2 * 150000);
    nCompared++;
    nMismatch++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  end
endmodule